// File: doc/BRIEF.md
# Fractional Clock Divider

This block derives a slower clock from a source clock by a divisor made of a whole part and a 12-bit fraction. Each output period lasts either the whole part or one more source cycle. A phase accumulator decides which periods get the extra cycle, so over a long run the output frequency is the source frequency divided by the whole part plus the fraction. No internal clock runs faster than the source: a long period simply keeps one more source pulse in its low phase.

A mode input picks integer-only operation, where the fraction is ignored, or first-order fractional operation. A one-cycle flag marks the start of every long period, so that logic downstream can count or track the stretch pattern. When the enable is dropped the output stops low and the accumulator clears. Each new enable therefore restarts the pattern in a known phase.

Top module: `frac_clk_div`

## Requirements
- R1: While `rst_n` is low, `clk_out` and `stretch` are 0 regardless of the other inputs.
- R2: Every output period lasts either D or D+1 source cycles, where D is the effective whole divisor. With `frac_mode` = 0, every period is exactly D cycles and `div_frac` has no effect.
- R3: With `frac_mode` = 1, a 12-bit accumulator (cleared on enable) adds `div_frac` once per period, modulo 4096. A period is D+1 cycles exactly when that addition carries out of bit 11. The first period after enable adds to zero.
- R4: With D = 6 and `div_frac` = 0x400 (0.25), periods repeat as 6, 6, 6, 7.
- R5: Over 4096 consecutive periods from enable, the total length is exactly 4096·D + `div_frac` source cycles.
- R6: `clk_out` is high for floor(D/2) cycles in both short and long periods. The extra cycle of a long period falls in the low phase.
- R7: A `div_int` value of 0 or 1 is treated as 2.
- R8: `div_int`, `div_frac` and `frac_mode` are sampled only on the clock edge that starts a period. A change in mid-period leaves the current period unchanged.
- R9: `stretch` is high for exactly one cycle, the first cycle of each long period, and is never high in a short period.
- R10: `clk_out` rises on the first edge at which `en` is sampled high. After an edge at which `en` is sampled low, both outputs are 0, and the accumulator restarts from zero on the next enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Run enable; low stops the output and clears the accumulator |
| frac_mode | input | 1 | 0 = integer-only, 1 = first-order fractional |
| div_int | input | INT_W | Whole part of the divisor (values below 2 are treated as 2) |
| div_frac | input | FRAC_W | Fractional part of the divisor in units of 1/4096 |
| clk_out | output | 1 | Divided clock, registered |
| stretch | output | 1 | One-cycle pulse at the start of each long period |

## Verification
The bound checker checks these on every cycle:
- Each period's length against the divisor sampled at its start, plus the stretch flag seen at its rising edge.
- The high-phase width.
- That `stretch` lasts one cycle, falls on a rising edge and appears only after a fractional-mode sample.
- That a low enable silences both outputs.

The bench scenarios cover the behaviour that needs the accumulator's history or a long window:
- The exact stretch sequence for a given fraction.
- The 6,6,6,7 pattern.
- The exact cycle total over 4096 periods.
- The restart of the pattern after re-enable.
- The boundary-only uptake of a new divisor.

// File: rtl/fcd_pkg.sv
// Package: shared definitions for the fractional clock divider.
// Assumes: fraction units of 1/2**FRAC_W; mode encoding fixed below.
package fcd_pkg;
    localparam int FCD_INT_W_DEF  = 8;
    localparam int FCD_FRAC_W_DEF = 12;
    localparam int FCD_MIN_DIV    = 2;

    typedef enum logic {
        FCD_MODE_INT  = 1'b0,
        FCD_MODE_FRAC = 1'b1
    } fcd_mode_e;
endpackage

// File: rtl/fcd_div_sel.sv
// Module: clamps the requested whole divisor to the legal minimum.
// Assumes: purely combinational; caller samples result at period start.
module fcd_div_sel #(
    parameter int INT_W = fcd_pkg::FCD_INT_W_DEF
) (
    input  logic [INT_W-1:0] div_req,
    output logic [INT_W-1:0] div_eff
);
    localparam logic [INT_W-1:0] MIN_DIV = INT_W'(fcd_pkg::FCD_MIN_DIV);

    // Purpose: replace divisors below the minimum with the minimum.
    always_comb begin
        if (div_req < MIN_DIV) div_eff = MIN_DIV;
        else                   div_eff = div_req;
    end
endmodule

// File: rtl/fcd_phase_acc.sv
// Module: first-order phase accumulator that decides which periods stretch.
// Assumes: step pulses once per period start; clear holds it at zero.
module fcd_phase_acc #(
    parameter int FRAC_W = fcd_pkg::FCD_FRAC_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              step,
    input  logic              frac_en,
    input  logic [FRAC_W-1:0] frac,
    output logic              carry
);
    logic [FRAC_W-1:0] acc_q;
    logic [FRAC_W:0]   sum;

    // Purpose: form the next phase and its carry out.
    always_comb begin
        sum   = {1'b0, acc_q} + {1'b0, frac};
        carry = frac_en & sum[FRAC_W];
    end

    // Purpose: advance the phase once per period in fractional mode only.
    always_ff @(posedge clk) begin
        if (!rst_n || clear)        acc_q <= '0;
        else if (step && frac_en)   acc_q <= sum[FRAC_W-1:0];
    end
endmodule

// File: rtl/fcd_period_gen.sv
// Module: counts source cycles within a period and shapes the output.
// Assumes: div_in >= 2, sampled together with long_in at each period start.
module fcd_period_gen #(
    parameter int INT_W = fcd_pkg::FCD_INT_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [INT_W-1:0] div_in,
    input  logic             long_in,
    output logic             load,
    output logic             clk_out,
    output logic             stretch
);
    localparam int CNT_W = INT_W + 1;

    logic             active_q, n_active;
    logic [CNT_W-1:0] cnt_q, n_cnt, last;
    logic [INT_W-1:0] div_q, n_div;
    logic             long_q, n_long;
    logic [CNT_W-1:0] n_half;

    // Purpose: locate the last cycle of the current period.
    always_comb begin
        last = {1'b0, div_q} + {{INT_W{1'b0}}, long_q} - CNT_W'(1);
        load = en && (!active_q || (cnt_q == last));
    end

    // Purpose: choose the next counter state and period descriptor.
    always_comb begin
        n_active = active_q;
        n_cnt    = cnt_q + CNT_W'(1);
        n_div    = div_q;
        n_long   = long_q;
        if (!en) begin
            n_active = 1'b0;
            n_cnt    = '0;
            n_long   = 1'b0;
        end else if (load) begin
            n_active = 1'b1;
            n_cnt    = '0;
            n_div    = div_in;
            n_long   = long_in;
        end
        n_half = {2'b00, n_div[INT_W-1:1]};
    end

    // Purpose: hold the period state and register glitch-free outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            cnt_q    <= '0;
            div_q    <= INT_W'(fcd_pkg::FCD_MIN_DIV);
            long_q   <= 1'b0;
            clk_out  <= 1'b0;
            stretch  <= 1'b0;
        end else begin
            active_q <= n_active;
            cnt_q    <= n_cnt;
            div_q    <= n_div;
            long_q   <= n_long;
            clk_out  <= n_active && (n_cnt < n_half);
            stretch  <= n_active && n_long && (n_cnt == '0);
        end
    end
endmodule

// File: rtl/frac_clk_div.sv
// Module: fractional clock divider top; integer or first-order fractional.
// Assumes: all inputs synchronous to clk; divisor taken at period starts.
module frac_clk_div #(
    parameter int INT_W  = fcd_pkg::FCD_INT_W_DEF,
    parameter int FRAC_W = fcd_pkg::FCD_FRAC_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              frac_mode,
    input  logic [INT_W-1:0]  div_int,
    input  logic [FRAC_W-1:0] div_frac,
    output logic              clk_out,
    output logic              stretch
);
    logic [INT_W-1:0] div_eff;
    logic             carry;
    logic             load;
    logic             frac_on;

    // Purpose: decode the operating mode.
    always_comb frac_on = (fcd_pkg::fcd_mode_e'(frac_mode) == fcd_pkg::FCD_MODE_FRAC);

    fcd_div_sel #(.INT_W(INT_W)) u_sel (
        .div_req (div_int),
        .div_eff (div_eff)
    );

    fcd_phase_acc #(.FRAC_W(FRAC_W)) u_acc (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (!en),
        .step    (load),
        .frac_en (frac_on),
        .frac    (div_frac),
        .carry   (carry)
    );

    fcd_period_gen #(.INT_W(INT_W)) u_gen (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en),
        .div_in  (div_eff),
        .long_in (carry),
        .load    (load),
        .clk_out (clk_out),
        .stretch (stretch)
    );
endmodule

// File: rtl/fcd_chk.sv
// Checker: port-level properties of the divider, bound to the top.
// Assumes: inputs are sampled by the design on the edge before a rise.
module fcd_chk #(
    parameter int INT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en,
    input logic             frac_mode,
    input logic [INT_W-1:0] div_int,
    input logic             clk_out,
    input logic             stretch
);
    logic [INT_W-1:0] div_d, div_cl, div_c;
    logic             long_c, valid_c;
    logic [INT_W:0]   len_c, exp_len;
    logic [INT_W-1:0] hi_c;

    // Purpose: clamp the divisor seen at the previous edge.
    always_comb begin
        div_cl  = (div_d < INT_W'(2)) ? INT_W'(2) : div_d;
        exp_len = {1'b0, div_c} + {{INT_W{1'b0}}, long_c};
    end

    // Purpose: track period length, high width and start-of-period facts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_d <= '0; div_c <= '0; long_c <= 1'b0; valid_c <= 1'b0;
            len_c <= '0; hi_c <= '0;
        end else begin
            div_d <= div_int;
            if (clk_out && !$past(clk_out)) begin
                div_c   <= div_cl;
                long_c  <= stretch;
                valid_c <= en;
                len_c   <= (INT_W+1)'(1);
                hi_c    <= INT_W'(1);
            end else begin
                len_c <= len_c + (INT_W+1)'(1);
                if (clk_out) hi_c <= hi_c + INT_W'(1);
                if (!en) valid_c <= 1'b0;
            end
        end
    end

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!clk_out && !stretch)); // R10
    AST_STRETCH_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        stretch |=> !stretch); // R9
    AST_STRETCH_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        stretch |-> $rose(clk_out)); // R9
    AST_INT_NO_STRETCH: assert property (@(posedge clk) disable iff (!rst_n)
        stretch |-> $past(frac_mode)); // R2
    AST_PERIOD_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(clk_out) && valid_c && en) |-> (len_c == exp_len)); // R2
    AST_HIGH_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(clk_out) && valid_c && en && $past(en)) |-> (hi_c == (div_c >> 1))); // R6
endmodule

bind frac_clk_div fcd_chk #(.INT_W(INT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .frac_mode (frac_mode),
    .div_int   (div_int),
    .clk_out   (clk_out),
    .stretch   (stretch)
);

// File: tb/frac_clk_div_tb.sv
module frac_clk_div_tb;
    localparam int INT_W  = 8;
    localparam int FRAC_W = 12;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              en = 1'b0;
    logic              frac_mode = 1'b0;
    logic [INT_W-1:0]  div_int = 8'd4;
    logic [FRAC_W-1:0] div_frac = '0;
    logic              clk_out, stretch;

    always #2 clk = ~clk;

    frac_clk_div #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .en(en), .frac_mode(frac_mode),
        .div_int(div_int), .div_frac(div_frac),
        .clk_out(clk_out), .stretch(stretch)
    );

    int n_chk = 0, n_err = 0, cyc = 0;
    int acc_m = 0;
    bit done = 0;

    task automatic check(bit ok, string req, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int eff_div(int d);
        return (d < 2) ? 2 : d;
    endfunction

    // Watchdog: a hung run counts as one failed check.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000 && !done) begin
            done = 1;
            n_chk++; n_err++;
            $display("FAIL watchdog R2 actual=%0d expected=%0d", cyc, 190000);
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    // Measure one period starting at the current (rising) sample.
    task automatic meas(output int len, output int hi, output int st0, output int stn);
        bit cur;
        len = 0; hi = 0; stn = 0; st0 = int'(stretch);
        forever begin
            cur = clk_out;
            len++;
            if (cur) hi++;
            if (stretch) stn++;
            @(negedge clk);
            if ((clk_out && !cur) || len > 5000) break;
        end
    endtask

    // Restart with new settings; first sample lands on the first high cycle.
    task automatic start(int d, int f, bit m);
        en = 0;
        @(negedge clk); @(negedge clk);
        div_int = INT_W'(d); div_frac = FRAC_W'(f); frac_mode = m;
        en = 1;
        acc_m = 0;
        @(negedge clk);
        check(clk_out === 1'b1, "R10 first edge high", int'(clk_out), 1);
    endtask

    // Measure n periods and compare with the bench model.
    task automatic run(int n, int d, int f, bit m, string tag);
        int len, hi, st0, stn, el;
        for (int p = 0; p < n; p++) begin
            el = 0;
            if (m) begin
                if (acc_m + f >= 4096) el = 1;
                acc_m = (acc_m + f) % 4096;
            end
            meas(len, hi, st0, stn);
            check(len == eff_div(d) + el, tag, len, eff_div(d) + el);
            check(hi == eff_div(d) / 2, "R6 high width", hi, eff_div(d) / 2);
            check(st0 == el && stn == el, "R9 stretch flag", stn, el);
        end
    endtask

    initial begin
        int r, len, hi, st0, stn, total, d, f;
        bit m;
        r = $urandom(32'd20240611);

        // R1: reset holds outputs low even with enable high
        en = 1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check(!clk_out && !stretch, "R1 reset quiet", int'(clk_out), 0);
        end
        rst_n = 1;

        // R4: 6.25 pattern
        start(6, 1024, 1);
        run(8, 6, 1024, 1, "R4 pattern 6/6/6/7");

        // R2: integer mode ignores a large fraction
        start(7, 4095, 0);
        run(6, 7, 4095, 0, "R2 integer mode");

        // R3: odd fraction stretch sequence
        start(5, 3000, 1);
        run(10, 5, 3000, 1, "R3 carry sequence");

        // R7: clamp of 0 and 1
        start(0, 0, 0);
        run(4, 0, 0, 0, "R7 clamp 0");
        start(1, 2048, 1);
        run(4, 1, 2048, 1, "R7 clamp 1");

        // R8: change divisor in mid-period
        start(4, 0, 0);
        div_int = 8'd9;
        meas(len, hi, st0, stn);
        check(len == 4, "R8 current period kept", len, 4);
        run(3, 9, 0, 0, "R8 new divisor");

        // R10: disable silences outputs, re-enable restarts phase
        start(6, 1024, 1);
        run(2, 6, 1024, 1, "R4 partial");
        en = 0;
        @(negedge clk);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check(!clk_out && !stretch, "R10 idle quiet", int'(clk_out), 0);
        end
        start(6, 1024, 1);
        run(4, 6, 1024, 1, "R10 restart phase");

        // R5: exact long-term total over 4096 periods
        start(3, 1365, 1);
        total = 0;
        for (int p = 0; p < 4096; p++) begin
            meas(len, hi, st0, stn);
            total += len;
        end
        check(total == 4096 * 3 + 1365, "R5 long-term total", total, 4096 * 3 + 1365);

        // R3: constrained random settings
        for (int s = 0; s < 30; s++) begin
            d = $urandom_range(0, 24);
            f = $urandom_range(0, 4095);
            m = 1'($urandom_range(0, 1));
            start(d, f, m);
            run(10, d, f, m, m ? "R3 random frac" : "R2 random int");
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule